// File: doc/BRIEF.md
# Bit-Plane Coder Phase Sequencer

This block is the top-level control machine of a bit-plane block coder. It has no datapath of its own. It steps the coder's working units through their work by raising one enable at a time and waiting for that unit's one-cycle finish pulse.

Each bit plane is handled in two phases:

- **Preprocessing.** A layer-generation unit loads the plane's magnitude bits and clears the visited buffer. A buffer-fill unit then sets up the five internal coding buffers.
- **Generation.** A pass-judgement unit runs three times, and a pass code tells it which coding pass to run: significance, then refinement, then cleanup.

After cleanup the sequencer moves to the next lower plane and goes back to preprocessing. When the last plane is finished it gives a one-cycle done pulse.

The host starts a job by pulsing `start` while the block is idle. In the same cycle it presents the number of magnitude planes on `plane_count`. The working units see only their own enable, the shared pass code and the current plane index. All pins are plain control pins, so there is no back-pressure. A unit holds off the sequencer simply by delaying its finish pulse.

Top module: `bpc_phase_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), the next state is idle. In idle, `layer_en`, `fill_en`, `judge_en`, `busy`, `done` and `preproc` are all low.
- R2: `start` is accepted only in idle. With `plane_count` = N > 0, the cycle after the start edge shows `layer_en`=1, `busy`=1 and `plane_idx`=N-1. A `start` while busy changes nothing.
- R3: At most one of `layer_en`, `fill_en` and `judge_en` is high in any cycle. None of them is high in idle or in the done cycle.
- R4: The sequencer stays in a state until the finish input of the unit it enabled is high at a clock edge. Finish pulses from other units, and any finish pulse while idle, are ignored.
- R5: Within a plane, the enable order is `layer_en`, then `fill_en`, then `judge_en`.
- R6: `judge_en` is raised three times per plane, with `pass_sel` = 0 (significance), then 1 (refinement), then 2 (cleanup). Each `judge_fin` moves to the next pass.
- R7: After the cleanup pass of a plane whose `plane_idx` is greater than 0, the next cycle shows `layer_en`=1 and `plane_idx` one lower.
- R8: After the cleanup pass of plane 0, `done` is high for exactly one cycle with all enables low. The block is then idle again.
- R9: A start with `plane_count` = 0 gives the one-cycle `done` in the next cycle, without raising any enable.
- R10: `preproc` is high exactly while `layer_en` or `fill_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job start pulse, honoured only in idle |
| plane_count | input | PW | Number of magnitude planes, sampled with start |
| layer_fin | input | 1 | Layer-generation unit finished |
| fill_fin | input | 1 | Buffer-fill unit finished |
| judge_fin | input | 1 | Pass-judgement unit finished the current pass |
| layer_en | output | 1 | Enable for the layer-generation unit |
| fill_en | output | 1 | Enable for the buffer-fill unit |
| judge_en | output | 1 | Enable for the pass-judgement unit |
| pass_sel | output | 2 | Current pass: 0 significance, 1 refinement, 2 cleanup |
| plane_idx | output | PW | Index of the plane being coded (valid while busy) |
| preproc | output | 1 | High during the preprocessing phase |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse at job end |

## Verification
A wrong state register shows up in the very next cycle. The enable pattern, the pass code or the plane index then differs from the order the requirements fix, because every output decodes directly from registered state.

A corrupted plane counter is seen as a wrong `plane_idx` in the next cycle. It also shows at the end of the job, as a `done` pulse that comes early, comes late or never arrives.

A pass counter that skips or repeats a value is caught at the next `judge_fin`. So is a finish pulse that is taken from the wrong unit: it makes the sequencer leave a state while its own unit is still busy.

The bench drives spurious finish and start pulses in every waiting cycle, so a design that leaves a state too early shows it within one cycle.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LAYER  = 3'd1,
    ST_FILL   = 3'd2,
    ST_JUDGE  = 3'd3,
    ST_FINISH = 3'd4
  } bpc_state_e;

  typedef enum logic [1:0] {
    PASS_SIG = 2'd0,
    PASS_REF = 2'd1,
    PASS_CLN = 2'd2
  } bpc_pass_e;

  localparam int N_UNITS    = 3;
  localparam int UNIT_LAYER = 0;
  localparam int UNIT_FILL  = 1;
  localparam int UNIT_JUDGE = 2;

  // State in which a given unit holds its enable.
  function automatic bpc_state_e unit_state(input int unit);
    case (unit)
      UNIT_LAYER: unit_state = ST_LAYER;
      UNIT_FILL:  unit_state = ST_FILL;
      default:    unit_state = ST_JUDGE;
    endcase
  endfunction
endpackage

// File: rtl/bpc_plane_counter.sv
module bpc_plane_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic         last_o,
  output logic [W-1:0] idx_o
);
  logic [W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)       remain_q <= '0;
    else if (load) remain_q <= load_val;
    else if (dec)  remain_q <= remain_q - W'(1);
  end

  assign last_o = (remain_q == W'(1));
  assign idx_o  = remain_q - W'(1);
endmodule

// File: rtl/bpc_pass_seq.sv
module bpc_pass_seq
  import bpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      adv,
  output bpc_pass_e pass_o,
  output logic      last_o
);
  bpc_pass_e pass_q;

  always_ff @(posedge clk) begin
    if (rst || clr) pass_q <= PASS_SIG;
    else if (adv) begin
      case (pass_q)
        PASS_SIG: pass_q <= PASS_REF;
        PASS_REF: pass_q <= PASS_CLN;
        default:  pass_q <= PASS_SIG;
      endcase
    end
  end

  assign pass_o = pass_q;
  assign last_o = (pass_q == PASS_CLN);
endmodule

// File: rtl/bpc_enable_decode.sv
module bpc_enable_decode
  import bpc_pkg::*;
(
  input  bpc_state_e           state_i,
  input  logic [N_UNITS-1:0]   fin_i,
  output logic [N_UNITS-1:0]   en_o,
  output logic                 fin_seen_o
);
  logic [N_UNITS-1:0] hit;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    assign en_o[u] = (state_i == unit_state(u));
    assign hit[u]  = en_o[u] & fin_i[u];
  end

  // Only the finish of the currently enabled unit counts.
  assign fin_seen_o = |hit;
endmodule

// File: rtl/bpc_phase_ctrl.sv
module bpc_phase_ctrl
  import bpc_pkg::*;
#(
  parameter int MAX_PLANES = 15,
  localparam int PW = $clog2(MAX_PLANES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [PW-1:0] plane_count,
  input  logic          layer_fin,
  input  logic          fill_fin,
  input  logic          judge_fin,
  output logic          layer_en,
  output logic          fill_en,
  output logic          judge_en,
  output logic [1:0]    pass_sel,
  output logic [PW-1:0] plane_idx,
  output logic          preproc,
  output logic          busy,
  output logic          done
);
  bpc_state_e         state_q, state_d;
  logic [N_UNITS-1:0] en_vec, fin_vec;
  logic               fin_seen;
  logic               plane_last, pass_last;
  logic               accept, plane_end;
  bpc_pass_e          pass_cur;

  assign fin_vec[UNIT_LAYER] = layer_fin;
  assign fin_vec[UNIT_FILL]  = fill_fin;
  assign fin_vec[UNIT_JUDGE] = judge_fin;

  bpc_enable_decode u_dec (
    .state_i    (state_q),
    .fin_i      (fin_vec),
    .en_o       (en_vec),
    .fin_seen_o (fin_seen)
  );

  assign accept    = (state_q == ST_IDLE) && start;
  assign plane_end = (state_q == ST_JUDGE) && fin_seen && pass_last;

  bpc_plane_counter #(.W(PW)) u_planes (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .dec      (plane_end),
    .load_val (plane_count),
    .last_o   (plane_last),
    .idx_o    (plane_idx)
  );

  bpc_pass_seq u_pass (
    .clk    (clk),
    .rst    (rst),
    .clr    (state_q == ST_FILL),
    .adv    ((state_q == ST_JUDGE) && fin_seen),
    .pass_o (pass_cur),
    .last_o (pass_last)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = (plane_count == '0) ? ST_FINISH : ST_LAYER;
      ST_LAYER:  if (fin_seen) state_d = ST_FILL;
      ST_FILL:   if (fin_seen) state_d = ST_JUDGE;
      ST_JUDGE:  if (fin_seen && pass_last) state_d = plane_last ? ST_FINISH : ST_LAYER;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign layer_en = en_vec[UNIT_LAYER];
  assign fill_en  = en_vec[UNIT_FILL];
  assign judge_en = en_vec[UNIT_JUDGE];
  assign pass_sel = pass_cur;
  assign preproc  = (state_q == ST_LAYER) || (state_q == ST_FILL);
  assign busy     = (state_q == ST_LAYER) || (state_q == ST_FILL) || (state_q == ST_JUDGE);
  assign done     = (state_q == ST_FINISH);
endmodule

// File: rtl/bpc_phase_ctrl_chk.sv
module bpc_phase_ctrl_chk #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          layer_fin,
  input logic          fill_fin,
  input logic          judge_fin,
  input logic          layer_en,
  input logic          fill_en,
  input logic          judge_en,
  input logic [1:0]    pass_sel,
  input logic [PW-1:0] plane_idx,
  input logic          preproc,
  input logic          busy,
  input logic          done
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> !busy && !done && !layer_en && !fill_en && !judge_en);

  a_r3_one_enable: assert property (@(posedge clk) disable iff (rst)
    $onehot0({layer_en, fill_en, judge_en}));

  a_r4_layer_hold: assert property (@(posedge clk) disable iff (rst)
    layer_en && !layer_fin |=> layer_en);

  a_r4_fill_hold: assert property (@(posedge clk) disable iff (rst)
    fill_en && !fill_fin |=> fill_en);

  a_r2_start_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && start && !layer_fin && !fill_fin && !judge_fin
      |=> $stable({layer_en, fill_en, judge_en, pass_sel, plane_idx}));

  a_r5_layer_to_fill: assert property (@(posedge clk) disable iff (rst)
    layer_en && layer_fin |=> fill_en);

  a_r5_fill_to_judge: assert property (@(posedge clk) disable iff (rst)
    fill_en && fill_fin |=> judge_en && pass_sel == 2'd0);

  a_r6_pass_step: assert property (@(posedge clk) disable iff (rst)
    judge_en && judge_fin && pass_sel != 2'd2
      |=> judge_en && pass_sel == $past(pass_sel) + 2'd1);

  a_r7_plane_step: assert property (@(posedge clk) disable iff (rst)
    judge_en && judge_fin && pass_sel == 2'd2 && plane_idx != '0
      |=> layer_en && plane_idx == $past(plane_idx) - PW'(1));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && !busy);

  a_r10_preproc_phase: assert property (@(posedge clk) disable iff (rst)
    preproc == (layer_en || fill_en));
endmodule

bind bpc_phase_ctrl bpc_phase_ctrl_chk #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .layer_fin (layer_fin),
  .fill_fin  (fill_fin),
  .judge_fin (judge_fin),
  .layer_en  (layer_en),
  .fill_en   (fill_en),
  .judge_en  (judge_en),
  .pass_sel  (pass_sel),
  .plane_idx (plane_idx),
  .preproc   (preproc),
  .busy      (busy),
  .done      (done)
);

// File: tb/bpc_phase_ctrl_test.sv
`timescale 1ns/1ps
module bpc_phase_ctrl_test;
  localparam int MAXP = 15;
  localparam int PW   = $clog2(MAXP + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [PW-1:0] plane_count = '0;
  logic          layer_fin = 1'b0, fill_fin = 1'b0, judge_fin = 1'b0;
  logic          layer_en, fill_en, judge_en, preproc, busy, done;
  logic [1:0]    pass_sel;
  logic [PW-1:0] plane_idx;

  int vectors = 0;
  int fails   = 0;

  always #10 clk = ~clk;

  bpc_phase_ctrl #(.MAX_PLANES(MAXP)) uut (
    .clk(clk), .rst(rst), .start(start), .plane_count(plane_count),
    .layer_fin(layer_fin), .fill_fin(fill_fin), .judge_fin(judge_fin),
    .layer_en(layer_en), .fill_en(fill_en), .judge_en(judge_en),
    .pass_sel(pass_sel), .plane_idx(plane_idx), .preproc(preproc),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " enables"}, int'({judge_en, fill_en, layer_en}), 0);
    chk({req, " busy"}, int'(busy), 0);
    chk({req, " done"}, int'(done), 0);
    chk({req, " preproc"}, int'(preproc), 0);
  endtask

  // Serve one unit u (0 layer, 1 fill, 2 judge) after d waiting cycles.
  task automatic serve(input int u, input int ps, input int p, input int d);
    for (int k = 0; k <= d; k++) begin
      chk("R5 R3 enable vector", int'({judge_en, fill_en, layer_en}), 1 << u);
      if (u == 2) chk("R6 pass_sel", int'(pass_sel), ps);
      chk("R7 plane_idx", int'(plane_idx), p);
      chk("R10 preproc", int'(preproc), (u != 2) ? 1 : 0);
      chk("R2 busy", int'(busy), 1);
      chk("R8 done low mid-job", int'(done), 0);
      // R4: before its own finish, other units pulse finish; R2: start while busy.
      layer_fin   = (u == 0) ? (k == d) : (k < d);
      fill_fin    = (u == 1) ? (k == d) : (k < d);
      judge_fin   = (u == 2) ? (k == d) : (k < d);
      start       = (k < d);
      plane_count = PW'(7);
      @(negedge clk);
    end
    layer_fin = 1'b0; fill_fin = 1'b0; judge_fin = 1'b0; start = 1'b0;
  endtask

  task automatic run_job(input int np);
    plane_count = PW'(np);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (np == 0) begin
      chk("R9 done after zero planes", int'(done), 1);
      chk("R9 no enable", int'({judge_en, fill_en, layer_en}), 0);
      chk("R9 busy", int'(busy), 0);
      @(negedge clk);
      chk_idle("R8 idle after zero-plane job");
    end else begin
      for (int p = np - 1; p >= 0; p--) begin
        serve(0, 0, p, (p + 0) % 4);
        serve(1, 0, p, (p + 2) % 4);
        for (int ps = 0; ps < 3; ps++) serve(2, ps, p, (p + 4 + ps) % 4);
      end
      chk("R8 done pulse", int'(done), 1);
      chk("R8 R3 enables low at done", int'({judge_en, fill_en, layer_en}), 0);
      chk("R8 busy low at done", int'(busy), 0);
      @(negedge clk);
      chk_idle("R8 idle after done");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 after reset");

    // R4: finish pulses while idle are ignored.
    layer_fin = 1'b1; fill_fin = 1'b1; judge_fin = 1'b1;
    @(negedge clk);
    layer_fin = 1'b0; fill_fin = 1'b0; judge_fin = 1'b0;
    chk_idle("R4 idle ignores finish");

    for (int np = 0; np <= 6; np++) run_job(np);
    run_job(MAXP);

    // R1: reset in the middle of a job.
    plane_count = PW'(3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 start accepted plane_idx", int'(plane_idx), 2);
    serve(0, 0, 2, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_idle("R1 mid-job reset");
    run_job(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule